// File: doc/BRIEF.md
# Network Controller Command and Status Register Block

This block is the host-facing control word pair of a network controller. A 16-bit status word collects event flags raised by pulses from the transmit command unit, the receive unit, the management interface and the flow-control logic. Software clears those flags by writing ones. The same word also shows the current state of both units, which those units drive in. A 16-bit command word carries one opcode for each unit, an interrupt mask bit and a self-interrupt request bit. A 32-bit pointer register supplies the operand that travels with each command.

An accepted opcode write becomes a pending command for its unit. The command is shown on a valid/accept pair together with a snapshot of the pointer. Valid stays high, and the opcode and pointer stay stable, until the unit gives a one-cycle accept. The unit can hold off by leaving accept low for as long as it likes. While a command waits, the opcode field reads back non-zero, so software can poll it to know when to issue the next one. A new opcode for a busy unit is dropped. Accept while nothing is pending has no effect. One receive opcode, load base address (6), stays visible in the field after acceptance. The interrupt output is the OR of all event flags, gated by the mask bit.

Top module: `nic_csr_top`

## Requirements
- R1: After reset the status word (with zero state inputs), the command word, both command valids and the interrupt output are all 0.
- R2: An event pulse sets its status bit on the next clock edge: bit 15 command done, bit 14 frame received, bit 13 command unit left active, bit 12 receiver left ready, bit 11 management cycle done, bit 8 flow-control pause. Status bits 9, 1 and 0 always read 0.
- R3: A status write clears every event bit (mask 0xFD00) written as 1. Bits written as 0, and non-event bit positions, are unchanged.
- R4: An event pulse in the same cycle as a write-1 clear of that bit leaves the bit set.
- R5: A command write with bit 9 set sets status bit 10. Command bit 9 always reads 0.
- R6: Command bit 8 is a stored interrupt mask that reads back. The interrupt output is high exactly when some event bit is set and the mask is 0.
- R7: Status bits 7:6 show the command-unit state input. Bits 5:2 show the receive-state code (0 idle, 1 suspended, 2 no resources, 4 ready) in bits 4:2, plus bit 5 set when no receive buffers remain.
- R8: A legal non-zero command-unit opcode in command bits 7:4 (1 start, 2 resume, 4 load stats address, 5 dump stats, 6 load base, 7 dump and reset) raises the command-unit valid with that opcode. Valid, opcode and pointer hold until accept. The field reads the opcode until accept and 0 from the cycle after.
- R9: Receive opcodes in command bits 2:0 (1 start, 2 resume, 4 abort, 6 load base, 7 resume without resources) are issued the same way. After acceptance of opcode 6, valid drops but the field still reads 6 until the next receive opcode write.
- R10: Opcodes outside the legal sets (command unit 3 and 8 to 15, receive 3 and 5) are discarded: the field reads 0 and no valid is raised.
- R11: While a unit's command is pending, a new opcode written for that unit is ignored. Its field, opcode and pointer are unchanged.
- R12: The pointer given with a command is the pointer register value at the command write, including a pointer write in that same cycle. Later pointer writes do not change it.
- R13: The two units are independent: one write can issue to both, and each clears on its own accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stat_wr_i | input | 1 | Status word write strobe (write-1-to-clear) |
| stat_wdata_i | input | 16 | Status write data |
| cmd_wr_i | input | 1 | Command word write strobe |
| cmd_wdata_i | input | 16 | Command write data |
| ptr_wr_i | input | 1 | Pointer register write strobe |
| ptr_wdata_i | input | 32 | Pointer write data |
| status_o | output | 16 | Status word readback |
| cmd_o | output | 16 | Command word readback |
| ev_tx_done_i | input | 1 | Command finished pulse |
| ev_rx_frame_i | input | 1 | Frame received pulse |
| ev_cu_idle_i | input | 1 | Command unit left active pulse |
| ev_ru_stop_i | input | 1 | Receiver left ready pulse |
| ev_mgmt_i | input | 1 | Management cycle done pulse |
| ev_pause_i | input | 1 | Flow-control pause pulse |
| cu_state_i | input | 2 | Command unit state code |
| ru_state_i | input | 3 | Receive state code |
| ru_nobuf_i | input | 1 | No receive buffers left |
| cu_valid_o | output | 1 | Command unit request valid |
| cu_op_o | output | 4 | Command unit opcode |
| cu_ptr_o | output | 32 | Pointer snapshot for command unit |
| cu_accept_i | input | 1 | Command unit accept pulse |
| ru_valid_o | output | 1 | Receive unit request valid |
| ru_op_o | output | 3 | Receive unit opcode |
| ru_ptr_o | output | 32 | Pointer snapshot for receive unit |
| ru_accept_i | input | 1 | Receive unit accept pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
On every cycle, assertions check these properties: a pending command keeps its valid, opcode and pointer until accept; only legal opcodes ever reach a unit; valid drops after accept; a raised event survives a simultaneous clear; a cleared bit goes low; and the interrupt only rises after a new event or an unmask. Some behaviour only the directed scenarios can show: the exact bit positions of each event and state field, the sticky receive opcode 6 reading back after acceptance, the dropping of writes to a busy unit, and the pointer snapshot taking a same-cycle pointer write.

// File: rtl/nic_csr_pkg.sv
package nic_csr_pkg;
  localparam int WORD_W = 16;
  localparam int PTR_W  = 32;
  localparam int CU_OP_W = 4;
  localparam int RU_OP_W = 3;

  // event positions in the status word
  localparam int B_TX_DONE  = 15;
  localparam int B_RX_FRAME = 14;
  localparam int B_CU_IDLE  = 13;
  localparam int B_RU_STOP  = 12;
  localparam int B_MGMT     = 11;
  localparam int B_SOFT     = 10;
  localparam int B_PAUSE    = 8;
  localparam logic [WORD_W-1:0] EVENT_MASK = 16'hFD00;

  // unit state field positions
  localparam int CU_ST_LO = 6;
  localparam int RU_ST_LO = 2;

  // command word field positions
  localparam int C_CU_LO = 4;
  localparam int C_RU_LO = 0;
  localparam int C_MASK  = 8;
  localparam int C_SOFT  = 9;

  typedef enum logic [CU_OP_W-1:0] {
    CU_NONE = 4'd0, CU_GO = 4'd1, CU_CONT = 4'd2, CU_STAT_PTR = 4'd4,
    CU_STAT_DUMP = 4'd5, CU_BASE = 4'd6, CU_STAT_CLR = 4'd7
  } cu_op_e;

  typedef enum logic [RU_OP_W-1:0] {
    RU_NONE = 3'd0, RU_GO = 3'd1, RU_CONT = 3'd2, RU_HALT = 3'd4,
    RU_BASE = 3'd6, RU_CONT_NR = 3'd7
  } ru_op_e;

  // one bit per opcode value: 1 = legal (value 0 is the no-op)
  localparam logic [(1<<CU_OP_W)-1:0] CU_LEGAL = 16'h00F7;
  localparam logic [(1<<RU_OP_W)-1:0] RU_LEGAL = 8'hD7;
endpackage

// File: rtl/nic_csr_status.sv
module nic_csr_status
  import nic_csr_pkg::*;
#(
  parameter int W = WORD_W,
  parameter logic [W-1:0] EVM = EVENT_MASK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_wr_i,
  input  logic [W-1:0] clr_data_i,
  input  logic [1:0]   cu_state_i,
  input  logic [2:0]   ru_state_i,
  input  logic         ru_nobuf_i,
  input  logic         mask_i,
  output logic [W-1:0] status_o,
  output logic         irq_o
);
  logic [W-1:0] ev_q;
  logic [W-1:0] clr_vec;
  logic [W-1:0] set_vec;

  assign clr_vec = clr_wr_i ? (clr_data_i & EVM) : '0;
  assign set_vec = set_i & EVM;

  always_ff @(posedge clk) begin
    if (!rst_n) ev_q <= '0;
    else        ev_q <= (ev_q & ~clr_vec) | set_vec;
  end

  always_comb begin
    status_o = ev_q;
    status_o[CU_ST_LO +: 2] = cu_state_i;
    status_o[RU_ST_LO +: 4] = {ru_nobuf_i, ru_state_i};
  end

  assign irq_o = (|ev_q) && !mask_i;

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((ev_q & $past(set_vec)) == $past(set_vec)));

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |=> ((ev_q & $past(clr_vec & ~set_vec)) == '0));

  assert_no_stray_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ev_q & ~EVM) == '0));
endmodule

// File: rtl/nic_csr_issue_slot.sv
module nic_csr_issue_slot #(
  parameter int OP_W = 4,
  parameter int PW = 32,
  parameter logic [(1<<OP_W)-1:0] LEGAL = '1,
  parameter bit STICKY_EN = 1'b0,
  parameter logic [OP_W-1:0] STICKY_OP = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic [OP_W-1:0] wr_op_i,
  input  logic [PW-1:0]   ptr_i,
  output logic [OP_W-1:0] field_o,
  output logic            valid_o,
  output logic [OP_W-1:0] op_o,
  output logic [PW-1:0]   ptr_o,
  input  logic            accept_i
);
  logic            pend_q;
  logic [OP_W-1:0] op_q;
  logic [PW-1:0]   ptr_q;
  logic            legal;
  logic            keep;
  logic            take;

  assign legal = LEGAL[wr_op_i];
  assign take  = wr_i && !pend_q;

  if (STICKY_EN) begin : g_sticky
    assign keep = (op_q == STICKY_OP);
  end else begin : g_plain
    assign keep = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      op_q   <= '0;
      ptr_q  <= '0;
    end else if (pend_q && accept_i) begin
      pend_q <= 1'b0;
      if (!keep) op_q <= '0;
    end else if (take) begin
      op_q   <= legal ? wr_op_i : '0;
      pend_q <= legal && (wr_op_i != '0);
      if (legal && (wr_op_i != '0)) ptr_q <= ptr_i;
    end
  end

  assign field_o = op_q;
  assign valid_o = pend_q;
  assign op_o    = op_q;
  assign ptr_o   = ptr_q;

  // R8 / R9: request held stable until accepted
  assert_valid_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !accept_i) |=> (valid_o && $stable(op_o) && $stable(ptr_o)));

  assert_drop_on_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && accept_i) |=> !valid_o);

  assert_legal_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (LEGAL[op_o] && (op_o != '0)));
endmodule

// File: rtl/nic_csr_top.sv
module nic_csr_top
  import nic_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_wr_i,
  input  logic [WORD_W-1:0] stat_wdata_i,
  input  logic              cmd_wr_i,
  input  logic [WORD_W-1:0] cmd_wdata_i,
  input  logic              ptr_wr_i,
  input  logic [PTR_W-1:0]  ptr_wdata_i,
  output logic [WORD_W-1:0] status_o,
  output logic [WORD_W-1:0] cmd_o,
  input  logic              ev_tx_done_i,
  input  logic              ev_rx_frame_i,
  input  logic              ev_cu_idle_i,
  input  logic              ev_ru_stop_i,
  input  logic              ev_mgmt_i,
  input  logic              ev_pause_i,
  input  logic [1:0]        cu_state_i,
  input  logic [2:0]        ru_state_i,
  input  logic              ru_nobuf_i,
  output logic              cu_valid_o,
  output logic [CU_OP_W-1:0] cu_op_o,
  output logic [PTR_W-1:0]  cu_ptr_o,
  input  logic              cu_accept_i,
  output logic              ru_valid_o,
  output logic [RU_OP_W-1:0] ru_op_o,
  output logic [PTR_W-1:0]  ru_ptr_o,
  input  logic              ru_accept_i,
  output logic              irq_o
);
  logic [PTR_W-1:0]   ptr_q;
  logic [PTR_W-1:0]   ptr_now;
  logic               mask_q;
  logic [WORD_W-1:0]  set_vec;
  logic [CU_OP_W-1:0] cu_field;
  logic [RU_OP_W-1:0] ru_field;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      mask_q <= 1'b0;
    end else begin
      if (ptr_wr_i) ptr_q  <= ptr_wdata_i;
      if (cmd_wr_i) mask_q <= cmd_wdata_i[C_MASK];
    end
  end

  // a pointer write in the same cycle as a command is seen by it
  assign ptr_now = ptr_wr_i ? ptr_wdata_i : ptr_q;

  always_comb begin
    set_vec = '0;
    set_vec[B_TX_DONE]  = ev_tx_done_i;
    set_vec[B_RX_FRAME] = ev_rx_frame_i;
    set_vec[B_CU_IDLE]  = ev_cu_idle_i;
    set_vec[B_RU_STOP]  = ev_ru_stop_i;
    set_vec[B_MGMT]     = ev_mgmt_i;
    set_vec[B_SOFT]     = cmd_wr_i && cmd_wdata_i[C_SOFT];
    set_vec[B_PAUSE]    = ev_pause_i;
  end

  nic_csr_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (set_vec),
    .clr_wr_i   (stat_wr_i),
    .clr_data_i (stat_wdata_i),
    .cu_state_i (cu_state_i),
    .ru_state_i (ru_state_i),
    .ru_nobuf_i (ru_nobuf_i),
    .mask_i     (mask_q),
    .status_o   (status_o),
    .irq_o      (irq_o)
  );

  nic_csr_issue_slot #(
    .OP_W(CU_OP_W), .PW(PTR_W), .LEGAL(CU_LEGAL),
    .STICKY_EN(1'b0), .STICKY_OP('0)
  ) u_cu_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (cmd_wr_i),
    .wr_op_i  (cmd_wdata_i[C_CU_LO +: CU_OP_W]),
    .ptr_i    (ptr_now),
    .field_o  (cu_field),
    .valid_o  (cu_valid_o),
    .op_o     (cu_op_o),
    .ptr_o    (cu_ptr_o),
    .accept_i (cu_accept_i)
  );

  nic_csr_issue_slot #(
    .OP_W(RU_OP_W), .PW(PTR_W), .LEGAL(RU_LEGAL),
    .STICKY_EN(1'b1), .STICKY_OP(RU_BASE)
  ) u_ru_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (cmd_wr_i),
    .wr_op_i  (cmd_wdata_i[C_RU_LO +: RU_OP_W]),
    .ptr_i    (ptr_now),
    .field_o  (ru_field),
    .valid_o  (ru_valid_o),
    .op_o     (ru_op_o),
    .ptr_o    (ru_ptr_o),
    .accept_i (ru_accept_i)
  );

  always_comb begin
    cmd_o = '0;
    cmd_o[C_MASK] = mask_q;
    cmd_o[C_CU_LO +: CU_OP_W] = cu_field;
    cmd_o[C_RU_LO +: RU_OP_W] = ru_field;
  end

  assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(set_vec != '0) || $fell(mask_q)));

  assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q |-> !irq_o);
endmodule

// File: tb/nic_csr_top_tb.sv
module nic_csr_top_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stat_wr = 1'b0, cmd_wr = 1'b0, ptr_wr = 1'b0;
  logic [15:0] stat_wd = '0, cmd_wd = '0;
  logic [31:0] ptr_wd = '0;
  logic [15:0] status, cmd;
  logic e_tx = 0, e_rx = 0, e_cu = 0, e_ru = 0, e_mg = 0, e_pa = 0;
  logic [1:0] cu_st = '0;
  logic [2:0] ru_st = '0;
  logic ru_nb = 1'b0;
  logic cu_v, ru_v, irq;
  logic [3:0] cu_op;
  logic [2:0] ru_op;
  logic [31:0] cu_ptr, ru_ptr;
  logic cu_acc = 1'b0, ru_acc = 1'b0;
  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nic_csr_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .stat_wr_i(stat_wr), .stat_wdata_i(stat_wd),
    .cmd_wr_i(cmd_wr), .cmd_wdata_i(cmd_wd),
    .ptr_wr_i(ptr_wr), .ptr_wdata_i(ptr_wd),
    .status_o(status), .cmd_o(cmd),
    .ev_tx_done_i(e_tx), .ev_rx_frame_i(e_rx), .ev_cu_idle_i(e_cu),
    .ev_ru_stop_i(e_ru), .ev_mgmt_i(e_mg), .ev_pause_i(e_pa),
    .cu_state_i(cu_st), .ru_state_i(ru_st), .ru_nobuf_i(ru_nb),
    .cu_valid_o(cu_v), .cu_op_o(cu_op), .cu_ptr_o(cu_ptr), .cu_accept_i(cu_acc),
    .ru_valid_o(ru_v), .ru_op_o(ru_op), .ru_ptr_o(ru_ptr), .ru_accept_i(ru_acc),
    .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmd_write(input logic [15:0] d);
    @(negedge clk); cmd_wr = 1'b1; cmd_wd = d;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic stat_write(input logic [15:0] d);
    @(negedge clk); stat_wr = 1'b1; stat_wd = d;
    @(negedge clk); stat_wr = 1'b0;
  endtask

  task automatic ptr_write(input logic [31:0] d);
    @(negedge clk); ptr_wr = 1'b1; ptr_wd = d;
    @(negedge clk); ptr_wr = 1'b0;
  endtask

  task automatic cu_ack();
    @(negedge clk); cu_acc = 1'b1;
    @(negedge clk); cu_acc = 1'b0;
  endtask

  task automatic ru_ack();
    @(negedge clk); ru_acc = 1'b1;
    @(negedge clk); ru_acc = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 status", status, 16'h0);
    chk("R1 cmd", cmd, 16'h0);
    chk("R1 valids/irq", {cu_v, ru_v, irq}, 0);
  endtask

  task automatic t_events();
    @(negedge clk); e_tx = 1;
    @(negedge clk); e_tx = 0;
    chk("R2 tx done bit15", status, 16'h8000);
    chk("R6 irq unmasked", irq, 1);
    @(negedge clk); {e_rx, e_cu, e_ru, e_mg, e_pa} = '1;
    @(negedge clk); {e_rx, e_cu, e_ru, e_mg, e_pa} = '0;
    chk("R2 all events", status, 16'hF900);
  endtask

  task automatic t_clear();
    stat_write(16'h8800);
    chk("R3 partial clear", status, 16'h7100);
    stat_write(16'h02FF);
    chk("R3 non-event bits no effect", status, 16'h7100);
    stat_write(16'hFFFF);
    chk("R3 full clear", status, 16'h0000);
    chk("R6 irq low when clear", irq, 0);
  endtask

  task automatic t_set_wins();
    @(negedge clk); e_rx = 1;
    @(negedge clk); e_rx = 0;
    @(negedge clk); e_rx = 1; stat_wr = 1; stat_wd = 16'h4000;
    @(negedge clk); e_rx = 0; stat_wr = 0;
    chk("R4 set beats clear", status, 16'h4000);
    stat_write(16'h4000);
    chk("R4 later clear", status, 16'h0000);
  endtask

  task automatic t_soft_mask();
    cmd_write(16'h0200);
    chk("R5 soft int bit10", status, 16'h0400);
    chk("R5 cmd bit9 reads 0", cmd, 16'h0000);
    chk("R6 irq from soft", irq, 1);
    cmd_write(16'h0100);
    chk("R6 mask readback", cmd, 16'h0100);
    chk("R6 masked irq", irq, 0);
    chk("R6 event kept under mask", status, 16'h0400);
    cmd_write(16'h0000);
    chk("R6 unmasked irq", irq, 1);
    stat_write(16'h0400);
    chk("R6 irq after clear", irq, 0);
  endtask

  task automatic t_state();
    @(negedge clk); cu_st = 2'd2; ru_st = 3'd4; ru_nb = 1;
    #1 chk("R7 state fields", status, 16'h00B0);
    @(negedge clk); cu_st = 2'd1; ru_st = 3'd1; ru_nb = 0;
    #1 chk("R7 suspended", status, 16'h0044);
    @(negedge clk); cu_st = 0; ru_st = 0;
  endtask

  task automatic t_cu_issue();
    ptr_write(32'h1234_5678);
    cmd_write(16'h0010);
    chk("R8 cu valid", {cu_v, cu_op}, {1'b1, 4'd1});
    chk("R8 cu field", cmd, 16'h0010);
    chk("R12 cu ptr", cu_ptr, 32'h1234_5678);
    repeat (3) @(negedge clk);
    chk("R8 cu held", {cu_v, cu_op}, {1'b1, 4'd1});
    ptr_write(32'h0000_DEAD);
    chk("R12 later ptr write ignored", cu_ptr, 32'h1234_5678);
    cu_ack();
    chk("R8 cu dropped", cu_v, 0);
    chk("R8 cu field cleared", cmd, 16'h0000);
  endtask

  task automatic t_ru_sticky();
    @(negedge clk); cmd_wr = 1; cmd_wd = 16'h0006; ptr_wr = 1; ptr_wd = 32'hCAFE_0000;
    @(negedge clk); cmd_wr = 0; ptr_wr = 0;
    chk("R9 ru valid op6", {ru_v, ru_op}, {1'b1, 3'd6});
    chk("R12 same-cycle ptr", ru_ptr, 32'hCAFE_0000);
    ru_ack();
    chk("R9 ru valid low", ru_v, 0);
    chk("R9 op6 sticks", cmd, 16'h0006);
    cmd_write(16'h0001);
    chk("R9 new ru op", {ru_v, cmd}, {1'b1, 16'h0001});
    ru_ack();
    chk("R9 start clears", cmd, 16'h0000);
  endtask

  task automatic t_illegal();
    cmd_write(16'h0030);
    chk("R10 cu op3 dropped", {cu_v, cmd}, 17'h0);
    cmd_write(16'h00F5);
    chk("R10 cu op15 ru op5 dropped", {cu_v, ru_v, cmd}, 18'h0);
  endtask

  task automatic t_pending();
    ptr_write(32'h0000_0AAA);
    cmd_write(16'h0020);
    ptr_write(32'h0000_0BBB);
    cmd_write(16'h0070);
    chk("R11 busy write ignored", cmd, 16'h0020);
    chk("R11 op/ptr unchanged", {cu_op, cu_ptr}, {4'd2, 32'h0000_0AAA});
    cu_ack();
    chk("R11 cleared after accept", cmd, 16'h0000);
  endtask

  task automatic t_both();
    ptr_write(32'h0000_0055);
    cmd_write(16'h0011);
    chk("R13 both valid", {cu_v, ru_v}, 2'b11);
    chk("R13 both ptr", {cu_ptr, ru_ptr}, {32'h55, 32'h55});
    ru_ack();
    chk("R13 ru only accepted", {cu_v, ru_v, cmd}, {2'b10, 16'h0010});
    cu_ack();
    chk("R13 cu accepted", {cu_v, cmd}, 17'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_events();
    t_clear();
    t_set_wins();
    t_soft_mask();
    t_state();
    t_cu_issue();
    t_ru_sticky();
    t_illegal();
    t_pending();
    t_both();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule